// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into shared memory. Buffers are described by a ring of descriptors that software hands over one at a time. The MAC delivers each frame as a byte stream marked with start and end flags, plus a CRC error flag on the last byte. While it has no frame to handle, the engine keeps reading the descriptor at its current ring position. When a frame starts, it checks the ownership flag it last read. If the engine owns the descriptor, it packs the bytes into 32-bit words and writes them into the buffer. It then writes back the status and length words, clears ownership and moves to the next ring slot. If software still holds the descriptor, the engine pulses a missed-frame output and drops the whole frame.

Each descriptor is two 32-bit words at an even word address. Word 0 holds the flags and a 24-bit byte address of the buffer. Word 1 holds the buffer size as a negative 16-bit value in its upper half and the received byte count in its low 12 bits. A single ring pointer word sets both the ring base and the ring size. The ring size is a power of two, coded as its log2.

Memory is word addressed and returns read data one cycle after the address. Every buffer address must be a multiple of four, and every buffer must hold between 1 and 4095 bytes. Between the last byte of one frame and the first byte of the next, the stream must stay idle for at least 8 cycles.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset the ring index is 0. The engine issues only reads, alternating between word 0 and word 1 of descriptor 0, and does not pulse `rx_miss`.
- R2: Descriptor word 0 bit 31 set to 1 means the engine owns the descriptor. If a frame starts while the current descriptor is not owned, `rx_miss` is high for exactly one cycle, the frame causes no memory write, and the ring index stays unchanged.
- R3: Byte n of an accepted frame goes to word address (buffer byte address / 4) + n/4, in lane n mod 4, with lane 0 in bits 7:0. Lanes of the last word beyond the final byte read as zero. Idle cycles inside a frame do not change the placement.
- R4: When a frame ends, word 0 is rewritten with bit 31 = 0 (returned to software) and bit 25 = 1 (start flag). Bit 24, the end flag, is 1 when the whole frame fit. Bits 23:0 keep the buffer address. Bits 29:26 are zero.
- R5: Word 1 is written next, at the following address. Bits 31:16 keep the stored negative size, bits 15:12 are zero, and bits 11:0 hold the number of bytes stored.
- R6: The buffer size in bytes is the two's complement negation of word 1 bits 31:16. A frame longer than that stores only that many bytes and writes nothing past the buffer. It is reported with the end flag clear and a count equal to the size. A frame of exactly the size is reported with the end flag set.
- R7: A CRC error on the last byte sets word 0 bit 30. The data and both descriptor words are still written, the descriptor is still returned, and the index still advances.
- R8: Ring pointer bits 31:29 hold log2 of the descriptor count, and bits 21:0 hold the ring base word address. Descriptor i sits at base + 2i.
- R9: After the last descriptor of the ring, the index wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_ptr | input | 32 | Ring size code (31:29) and ring base word address (21:0) |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_sop | input | 1 | First byte of a frame |
| rx_eop | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC error, valid together with rx_eop |
| mem_addr | output | 22 | Shared memory word address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_addr |
| rx_miss | output | 1 | One-cycle pulse: frame dropped because the descriptor was not owned |

## Verification
Take E as the clock edge that accepts a byte. A buffer word write is on the memory port in the cycle just after E, when E accepts the fourth byte of a word or the last byte stored. The missed-frame pulse is due in the cycle after the edge that accepts the start byte. For the edge that accepts the end byte, the status word write comes one cycle after that edge's data cycle, and the length word one cycle later. The driver stamps every expected write or pulse with its due cycle, taken from the bench's own cycle counter. The monitor checks address, data and cycle together, so a result that is correct but early or late is still caught.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int MLEN_W   = 12;
    localparam int BLEN_W   = 16;
    localparam int BADDR_W  = 24;
    localparam int CODE_W   = 3;
    localparam int MAX_LOG2 = 7;
    localparam int LANES    = 4;

    // descriptor word 0: ownership, flags, buffer byte address
    typedef struct packed {
        logic               own;
        logic               err;
        logic [3:0]         rsv;
        logic               stp;
        logic               enp;
        logic [BADDR_W-1:0] baddr;
    } rxd_word0_t;

    // descriptor word 1: negative buffer size, received count
    typedef struct packed {
        logic [BLEN_W-1:0] blen;
        logic [3:0]        rsv;
        logic [MLEN_W-1:0] mlen;
    } rxd_word1_t;

    typedef enum logic [2:0] {
        S_RD0, S_RD1, S_CAP, S_RECV, S_DROP, S_ENDF, S_WB0, S_WB1
    } rxd_state_t;

    function automatic logic [MLEN_W-1:0] buf_bytes(input logic [BLEN_W-1:0] blen);
        logic [BLEN_W-1:0] pos;
        pos = ~blen + 16'd1;
        return pos[MLEN_W-1:0];
    endfunction

    function automatic logic [MAX_LOG2-1:0] ring_mask(input logic [CODE_W-1:0] code);
        logic [MAX_LOG2:0] one_hot;
        one_hot = (MAX_LOG2+1)'(1) << code;
        return MAX_LOG2'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/rxd_ring_index.sv
module rxd_ring_index
    import rxd_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  logic [31:0]         ring_ptr,
    output logic [MAX_LOG2-1:0] idx,
    output logic [AW-1:0]       desc_addr
);

    logic [CODE_W-1:0]   code;
    logic [MAX_LOG2-1:0] mask;
    logic [AW-1:0]       base;
    logic                unused_ptr;

    assign code       = ring_ptr[31:29];
    assign mask       = ring_mask(code);
    assign base       = ring_ptr[AW-1:0];
    assign unused_ptr = ^ring_ptr[28:AW];
    assign desc_addr  = base + AW'({idx, 1'b0});

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (advance)
            idx <= (idx + 1'b1) & mask;
    end

    p_idx_in_ring_r9: assert property (@(posedge clk) disable iff (rst)
        (idx & ~mask) == '0);
    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (advance && idx == mask) |=> idx == '0);
    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        (advance && idx != mask) |=> idx == MAX_LOG2'($past(idx) + 1'b1));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(idx));

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              start,
    input  logic              eop,
    input  logic [7:0]        din,
    input  logic [AW-1:0]     buf_word,
    input  logic [MLEN_W-1:0] size,
    output logic              flush_vld,
    output logic [AW-1:0]     flush_addr,
    output logic [31:0]       flush_data,
    output logic [MLEN_W-1:0] count
);

    logic [MLEN_W-1:0] base_cnt;
    logic [1:0]        lane;
    logic              room;
    logic              last;
    logic [31:0]       acc;
    logic [31:0]       acc_next;

    assign base_cnt = start ? '0 : count;
    assign lane     = base_cnt[1:0];
    assign room     = base_cnt < size;
    assign last     = (lane == 2'd3) || eop ||
                      ({1'b0, base_cnt} + 13'd1 == {1'b0, size});

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign acc_next[8*l +: 8] = (lane == 2'(l)) ? din :
                                    (2'(l) > lane)  ? 8'h00 : acc[8*l +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            acc        <= '0;
            flush_vld  <= 1'b0;
            flush_addr <= '0;
            flush_data <= '0;
        end else begin
            flush_vld <= 1'b0;
            if (take) begin
                if (room) begin
                    acc   <= acc_next;
                    count <= base_cnt + 1'b1;
                    if (last) begin
                        flush_vld  <= 1'b1;
                        flush_addr <= buf_word + AW'(base_cnt >> 2);
                        flush_data <= acc_next;
                    end
                end else begin
                    count <= base_cnt;
                end
            end
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (take && !start) |-> count <= size);
    p_flush_in_buf_r6: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> (flush_addr - buf_word) < AW'(({1'b0, size} + 13'd3) >> 2));

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
    import rxd_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_crc_err,
    input  logic [AW-1:0]     desc_addr,
    input  logic [31:0]       mem_rdata,
    input  logic              flush_vld,
    input  logic [AW-1:0]     flush_addr,
    input  logic [31:0]       flush_data,
    input  logic [MLEN_W-1:0] pk_count,
    output logic              pk_take,
    output logic              pk_start,
    output logic              pk_eop,
    output logic [AW-1:0]     pk_buf_word,
    output logic [MLEN_W-1:0] pk_size,
    output logic              advance,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic              miss
);

    rxd_state_t state;
    rxd_word0_t c0, w0, d0;
    rxd_word1_t c1, w1, d1;
    logic [31:0] tmp0;
    logic        cache_vld, err_q, trunc;
    logic        polling, sop_now, owned;
    logic        unused_fields;

    assign polling  = (state == S_RD0) || (state == S_RD1) || (state == S_CAP);
    assign sop_now  = polling && rx_valid && rx_sop;
    assign owned    = cache_vld && c0.own;

    assign pk_start    = sop_now && owned;
    assign pk_take     = pk_start || (state == S_RECV && rx_valid);
    assign pk_eop      = rx_eop;
    assign pk_buf_word = pk_start ? AW'(c0.baddr >> 2) : AW'(w0.baddr >> 2);
    assign pk_size     = pk_start ? buf_bytes(c1.blen) : buf_bytes(w1.blen);
    assign advance     = (state == S_WB1);

    assign unused_fields = ^{c0.err, c0.rsv, c0.stp, c0.enp, c1.rsv, c1.mlen,
                             w0.own, w0.err, w0.rsv, w0.stp, w0.enp, w1.rsv, w1.mlen};

    always_comb begin
        d0       = '0;
        d0.err   = err_q;
        d0.stp   = 1'b1;
        d0.enp   = !trunc;
        d0.baddr = w0.baddr;
        d1       = '0;
        d1.blen  = w1.blen;
        d1.mlen  = pk_count;
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        if (flush_vld) begin
            mem_we    = 1'b1;
            mem_addr  = flush_addr;
            mem_wdata = flush_data;
        end else begin
            case (state)
                S_RD1: mem_addr = desc_addr + 1'b1;
                S_WB0: begin
                    mem_we    = 1'b1;
                    mem_wdata = d0;
                end
                S_WB1: begin
                    mem_we    = 1'b1;
                    mem_addr  = desc_addr + 1'b1;
                    mem_wdata = d1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_RD0;
            cache_vld <= 1'b0;
            miss      <= 1'b0;
            c0        <= '0;
            c1        <= '0;
            w0        <= '0;
            w1        <= '0;
            tmp0      <= '0;
            err_q     <= 1'b0;
            trunc     <= 1'b0;
        end else begin
            miss <= 1'b0;
            if (sop_now) begin
                if (owned) begin
                    w0    <= c0;
                    w1    <= c1;
                    trunc <= 1'b0;
                    err_q <= rx_eop && rx_crc_err;
                    state <= rx_eop ? S_ENDF : S_RECV;
                end else begin
                    miss  <= 1'b1;
                    state <= rx_eop ? S_RD0 : S_DROP;
                end
            end else begin
                case (state)
                    S_RD0: state <= S_RD1;
                    S_RD1: begin
                        tmp0  <= mem_rdata;
                        state <= S_CAP;
                    end
                    S_CAP: begin
                        c0        <= rxd_word0_t'(tmp0);
                        c1        <= rxd_word1_t'(mem_rdata);
                        cache_vld <= 1'b1;
                        state     <= S_RD0;
                    end
                    S_RECV: if (rx_valid) begin
                        if (pk_count >= pk_size)
                            trunc <= 1'b1;
                        if (rx_eop) begin
                            err_q <= rx_crc_err;
                            state <= S_ENDF;
                        end
                    end
                    S_DROP: if (rx_valid && rx_eop) state <= S_RD0;
                    S_ENDF: state <= S_WB0;
                    S_WB0:  state <= S_WB1;
                    S_WB1: begin
                        cache_vld <= 1'b0;
                        state     <= S_RD0;
                    end
                    default: state <= S_RD0;
                endcase
            end
        end
    end

    p_miss_single_r2: assert property (@(posedge clk) disable iff (rst)
        miss |=> !miss);
    p_miss_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        miss |-> !mem_we);
    p_flush_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        flush_vld |-> (state == S_RECV || state == S_ENDF));
    p_wb_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == S_WB0) |=> (mem_we && mem_addr == AW'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
    import rxd_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   ring_ptr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sop,
    input  logic          rx_eop,
    input  logic          rx_crc_err,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          rx_miss
);

    logic [MAX_LOG2-1:0] idx;
    logic [AW-1:0]       desc_addr;
    logic                advance;
    logic                pk_take, pk_start, pk_eop;
    logic [AW-1:0]       pk_buf_word;
    logic [MLEN_W-1:0]   pk_size, pk_count;
    logic                flush_vld;
    logic [AW-1:0]       flush_addr;
    logic [31:0]         flush_data;
    logic                unused_idx;

    assign unused_idx = ^idx;

    rxd_ring_index #(.AW(AW)) i_ring (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .ring_ptr  (ring_ptr),
        .idx       (idx),
        .desc_addr (desc_addr)
    );

    rxd_packer #(.AW(AW)) i_pack (
        .clk        (clk),
        .rst        (rst),
        .take       (pk_take),
        .start      (pk_start),
        .eop        (pk_eop),
        .din        (rx_data),
        .buf_word   (pk_buf_word),
        .size       (pk_size),
        .flush_vld  (flush_vld),
        .flush_addr (flush_addr),
        .flush_data (flush_data),
        .count      (pk_count)
    );

    rxd_ctrl #(.AW(AW)) i_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rx_valid    (rx_valid),
        .rx_sop      (rx_sop),
        .rx_eop      (rx_eop),
        .rx_crc_err  (rx_crc_err),
        .desc_addr   (desc_addr),
        .mem_rdata   (mem_rdata),
        .flush_vld   (flush_vld),
        .flush_addr  (flush_addr),
        .flush_data  (flush_data),
        .pk_count    (pk_count),
        .pk_take     (pk_take),
        .pk_start    (pk_start),
        .pk_eop      (pk_eop),
        .pk_buf_word (pk_buf_word),
        .pk_size     (pk_size),
        .advance     (advance),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .miss        (rx_miss)
    );

endmodule

// File: tb/test_rxd_ring_engine.sv
`timescale 1ns/1ps
module test_rxd_ring_engine;

    localparam int AW = 22;
    localparam logic [21:0] BASE = 22'h100;
    localparam int NDESC = 4;
    localparam logic [31:0] MISS_TAG = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] ring_ptr = {3'd2, 7'd0, BASE};
    logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_crc_err = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic [AW-1:0] mem_addr;
    logic mem_we;
    logic [31:0] mem_wdata, mem_rdata;
    logic rx_miss;

    logic [31:0] mem [0:4095];
    logic host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_data = '0;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    int          q_due[$];
    string       q_tag[$];

    bit          armed [NDESC];
    logic [15:0] blen_of [NDESC];
    int          exp_idx = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxd_ring_engine #(.AW(AW)) i_rxd_ring_engine (
        .clk(clk), .rst(rst), .ring_ptr(ring_ptr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_crc_err(rx_crc_err),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_miss(rx_miss)
    );

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    end

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (host_we) mem[host_addr] <= host_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every write or miss pulse pops one expected item
    always @(negedge clk) begin
        if (!rst && !done && (mem_we || rx_miss)) begin
            logic [31:0] act_a, act_d;
            act_a = rx_miss ? MISS_TAG : 32'(mem_addr);
            act_d = rx_miss ? 32'h0 : mem_wdata;
            if (q_addr.size() == 0) begin
                check(1'b0, "R2", "unexpected write/pulse addr", act_a, 32'h0);
            end else begin
                logic [31:0] ea, ed;
                int          due;
                string       tg;
                ea = q_addr.pop_front(); ed = q_data.pop_front();
                due = q_due.pop_front(); tg = q_tag.pop_front();
                check(act_a == ea, tg, "address", act_a, ea);
                check(act_d == ed, tg, "data", act_d, ed);
                check(cyc == due, tg, "cycle", 32'(cyc), 32'(due));
            end
        end
    end

    function automatic void push(input logic [31:0] a, input logic [31:0] d,
                                 input int due, input string tg);
        q_addr.push_back(a); q_data.push_back(d); q_due.push_back(due); q_tag.push_back(tg);
    endfunction

    function automatic logic [23:0] buf_byte_addr(input int i);
        return 24'h1000 + 24'(i) * 24'h400;
    endfunction

    task automatic host_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a[11:0]; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic arm(input int i, input logic [15:0] blen);
        host_write(32'(BASE) + 32'(2*i),     {1'b1, 7'd0, buf_byte_addr(i)});
        host_write(32'(BASE) + 32'(2*i) + 1, {blen, 16'h0});
        armed[i] = 1'b1;
        blen_of[i] = blen;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input int len, input logic [7:0] seed, input bit crc, input bit gaps);
        int i, size, stored, edge_e;
        logic [31:0] wacc;
        logic [7:0] b;
        i = exp_idx;
        size = armed[i] ? int'(16'(-blen_of[i])) : 0;
        stored = (len < size) ? len : size;
        wacc = '0;
        edge_e = 0;
        for (int k = 0; k < len; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_crc_err = 1'b0;
            end
            @(negedge clk);
            b = seed + 8'(k * 7);
            rx_valid = 1'b1; rx_data = b;
            rx_sop = (k == 0); rx_eop = (k == len - 1);
            rx_crc_err = crc && (k == len - 1);
            edge_e = cyc + 1;
            if (!armed[i]) begin
                if (k == 0) push(MISS_TAG, 32'h0, edge_e, "R2");
            end else if (k < stored) begin
                if (k % 4 == 0) wacc = '0;
                wacc[8*(k%4) +: 8] = b;
                if ((k % 4 == 3) || (k == stored - 1))
                    push(32'(buf_byte_addr(i) >> 2) + 32'(k/4), wacc, edge_e,
                         gaps ? "R3 gapped" : "R3");
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_crc_err = 1'b0;
        if (armed[i]) begin
            // R4 R7 R8: status word at base+2i; R5 R6: length word after it
            push(32'(BASE) + 32'(2*i),
                 {1'b0, crc, 4'b0, 1'b1, (len <= size), buf_byte_addr(i)},
                 edge_e + 1, crc ? "R7" : (len > size ? "R6" : "R4"));
            push(32'(BASE) + 32'(2*i) + 1, {blen_of[i], 4'b0, 12'(stored)},
                 edge_e + 2, len > size ? "R6" : "R5");
            armed[i] = 1'b0;
            exp_idx = (i + 1) % NDESC;  // R9 wrap
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: polling descriptor 0 at the ring base (R8), reads only
        check(mem_addr == BASE, "R1", "first poll address", 32'(mem_addr), 32'(BASE));
        check(!mem_we && !rx_miss, "R1", "idle after reset", {mem_we, rx_miss}, 32'h0);
        @(negedge clk);
        check(mem_addr == BASE + 22'd1, "R1", "second poll address", 32'(mem_addr), 32'(BASE) + 1);
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            check(!mem_we && !rx_miss, "R1", "no write while polling", {mem_we, rx_miss}, 32'h0);
        end

        arm(0, -16'sd1518);
        arm(1, -16'sd1518);
        arm(2, -16'sd10);
        arm(3, -16'sd1518);

        send(64, 8'h10, 1'b0, 1'b0);  // R3 R4 R5 full words
        send(5,  8'h40, 1'b1, 1'b0);  // R7 CRC error
        send(25, 8'h80, 1'b0, 1'b0);  // R6 truncated at 10 bytes
        send(1,  8'h22, 1'b0, 1'b0);  // single byte, last slot, R9 wrap
        send(30, 8'h33, 1'b0, 1'b0);  // R2 slot 0 not owned: miss
        arm(0, -16'sd1518);
        send(13, 8'h55, 1'b0, 1'b1);  // R2 index held at 0, R3 with gaps
        arm(1, -16'sd8);
        send(8,  8'h99, 1'b0, 1'b0);  // R6 exact fit keeps end flag
        arm(2, -16'sd1518);
        send(7,  8'h66, 1'b1, 1'b1);  // R7 with gaps

        repeat (20) @(negedge clk);
        check(q_addr.size() == 0, "R3", "results outstanding", 32'(q_addr.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule